// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a bank of 128 eight-bit registers. The master frames each transfer with an active-low select and clocks 16 bits, most significant first. The first bit gives the direction, the next seven give the register address and the last eight carry data. A direction bit of 1 stores the data field into the addressed register. A direction bit of 0 makes the block shift the addressed register out on MISO while the data field on MOSI is discarded.

The serial clock, data and select are not used as clocks. They pass through two-flop synchronisers into a faster local system clock, and their edges are detected there. A parallel port on the system side can read any register combinationally and write any register on a clock edge. If both sides write the same register in the same cycle, the serial write wins.

Top module: `spi_reg_port`

## Requirements
- R1: A frame is 16 SCK rising edges sampled MSB first: bit 15 is direction, bits 14..8 are the address and bits 7..0 are data. With direction 1, the addressed register takes the data field once the 16th bit is received.
- R2: With direction 0, the addressed register appears on MISO D7 first, one bit per falling SCK edge over the eight falling edges after the address. The master samples it on SCK rising edges 9 to 16.
- R3: In a read frame, the eight MOSI bits after the address change no register.
- R4: After the last read bit, MISO keeps that bit for as long as select stays low.
- R5: While select is high, MISO is 1. It returns to 1 within four system clocks of select rising.
- R6: A frame that ends with select high before 16 bits changes no register. The next frame starts again from bit 0.
- R7: The read value is captured when the address completes. A local write to that register during the data phase does not alter the bits shifted out.
- R8: The local port returns the register selected by the local address combinationally. A local write enable stores the local data into that register on the next clock edge.
- R9: When a serial write and a local write hit the same register in the same clock, the serial data is stored.
- R10: After reset every register reads 0 and MISO is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCK |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Active-low frame select |
| miso_o | output | 1 | Serial data to the master |
| loc_we_i | input | 1 | Local write enable |
| loc_addr_i | input | 7 | Local register address |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data |

## Verification
The assertions assume that SCK high and low phases each last several system clocks, so every synchronised edge is seen exactly once. They also assume that select changes only while SCK is low. The bench master holds each SCK phase for eight system clocks, changes MOSI and select only with SCK low, and keeps select high for at least eight clocks between frames. Local writes that must collide with a serial write are timed to the system clock in which the synchronised 16th rising edge is detected.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int SYNC_W = 3;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              csn_s_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              spi_we_o,
  output logic [ADDR_W-1:0] spi_addr_o,
  output logic [DATA_W-1:0] spi_wdata_o,
  output logic              miso_o
);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRM_CNT  = CNT_W'(FRAME_BITS);

  logic                  sck_q;
  logic                  sck_rise, sck_fall;
  logic [FRAME_BITS-2:0] sh_q;
  logic [FRAME_BITS-1:0] sh_next;
  logic [CNT_W-1:0]      cnt_q;
  logic                  is_wr_q;
  logic [DATA_W-1:0]     tx_q;

  assign sck_rise = sck_s_i & ~sck_q;
  assign sck_fall = ~sck_s_i & sck_q;
  assign sh_next  = {sh_q, mosi_s_i};

  assign rd_addr_o   = sh_next[ADDR_W-1:0];
  assign spi_addr_o  = sh_next[FRAME_BITS-2 -: ADDR_W];
  assign spi_wdata_o = sh_next[DATA_W-1:0];
  assign spi_we_o    = sck_rise & ~csn_s_i & (cnt_q == FRM_LAST) & sh_next[FRAME_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      tx_q    <= '0;
      miso_o  <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      if (csn_s_i) begin
        cnt_q   <= '0;
        is_wr_q <= 1'b0;
        miso_o  <= 1'b1;
      end else begin
        if (sck_rise && cnt_q != FRM_CNT) begin
          sh_q  <= sh_next[FRAME_BITS-2:0];
          cnt_q <= cnt_q + 1'b1;
          // header done: latch direction and snapshot the read data
          if (cnt_q == HDR_LAST) begin
            is_wr_q <= sh_next[HDR_BITS-1];
            tx_q    <= rd_data_i;
          end
        end
        if (sck_fall && !is_wr_q && cnt_q >= HDR_CNT && cnt_q < FRM_CNT) begin
          miso_o <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // R5
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> miso_o);
  // R6
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> (cnt_q == '0));
  // R4
  tail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FRM_CNT && !csn_s_i && $past(cnt_q == FRM_CNT)) |=> (csn_s_i || $stable(miso_o)));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_we_i,
  input  logic [ADDR_W-1:0] spi_addr_i,
  input  logic [DATA_W-1:0] spi_wdata_i,
  input  logic [ADDR_W-1:0] spi_raddr_i,
  output logic [DATA_W-1:0] spi_rdata_o,
  input  logic              loc_we_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [DATA_W-1:0] loc_wdata_i,
  output logic [DATA_W-1:0] loc_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (spi_we_i && spi_addr_i == ADDR_W'(i)) begin
        mem_q[i] <= spi_wdata_i;
      end else if (loc_we_i && loc_addr_i == ADDR_W'(i)) begin
        mem_q[i] <= loc_wdata_i;
      end
    end
  end

  assign spi_rdata_o = mem_q[spi_raddr_i];
  assign loc_rdata_o = mem_q[loc_addr_i];

  // R9
  spi_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_we_i |=> (mem_q[$past(spi_addr_i)] == $past(spi_wdata_i)));
  // R8
  loc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_we_i && !(spi_we_i && spi_addr_i == loc_addr_i))
      |=> (mem_q[$past(loc_addr_i)] == $past(loc_wdata_i)));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          csn_i,
  output logic          miso_o,
  input  logic          loc_we_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic [DW-1:0] loc_rdata_o
);
  logic [SYNC_W-1:0] pins_s;
  logic          spi_we;
  logic [AW-1:0] spi_addr, rd_addr;
  logic [DW-1:0] spi_wdata, rd_data;

  // bit order: {select, data, clock}; select resets idle-high
  spi_sync #(.W(SYNC_W), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, mosi_i, sck_i}),
    .q_o   (pins_s)
  );

  spi_frame #(.ADDR_W(AW), .DATA_W(DW)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (pins_s[0]),
    .mosi_s_i   (pins_s[1]),
    .csn_s_i    (pins_s[2]),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .spi_we_o   (spi_we),
    .spi_addr_o (spi_addr),
    .spi_wdata_o(spi_wdata),
    .miso_o     (miso_o)
  );

  spi_reg_bank #(.ADDR_W(AW), .DATA_W(DW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .spi_we_i   (spi_we),
    .spi_addr_i (spi_addr),
    .spi_wdata_i(spi_wdata),
    .spi_raddr_i(rd_addr),
    .spi_rdata_o(rd_data),
    .loc_we_i   (loc_we_i),
    .loc_addr_i (loc_addr_i),
    .loc_wdata_i(loc_wdata_i),
    .loc_rdata_o(loc_rdata_o)
  );
endmodule

// File: tb/sim_spi_reg_port.sv
`timescale 1ns/1ps
module sim_spi_reg_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic       miso;
  logic       loc_we = 1'b0;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  spi_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .loc_we_i(loc_we), .loc_addr_i(loc_addr),
    .loc_wdata_i(loc_wdata), .loc_rdata_o(loc_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compare every register against the model through the local port.
  task automatic sweep(input string req);
    int bad = -1;
    logic [7:0] got = '0;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      loc_addr = 7'(a);
      #1;
      if (bad < 0 && loc_rdata !== model[a]) begin
        bad = a;
        got = loc_rdata;
      end
    end
    if (bad < 0) chk(req, 0, 0);
    else chk(req, {got, 16'h0, 1'b0, 7'(bad)}, {model[bad], 16'h0, 1'b0, 7'(bad)});
  endtask

  // Drive nbits of a frame; lw_bit picks the bit whose rising edge gets
  // a one-cycle local write aligned to the synchronised edge detect.
  task automatic frame(input logic dir, input logic [6:0] addr, input logic [7:0] data,
                       input int nbits, input int lw_bit, output logic [7:0] rx);
    logic [15:0] w = {dir, addr, data};
    rx = '0;
    @(negedge clk);
    csn = 1'b0;
    wait_clk(4);
    for (int k = 0; k < nbits; k++) begin
      mosi = w[15-k];
      wait_clk(8);
      if (k >= 8) rx = {rx[6:0], miso};
      sck = 1'b1;
      if (k == lw_bit) begin
        wait_clk(2);
        loc_we = 1'b1;
        wait_clk(1);
        loc_we = 1'b0;
        wait_clk(5);
      end else begin
        wait_clk(8);
      end
      sck = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic release_sel();
    csn = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    logic [7:0] rx;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    chk("R10 miso after reset", miso, 1'b1);
    sweep("R10 registers zero after reset");

    // R1 serial writes
    frame(1'b1, 7'h00, 8'hA5, 16, -1, rx); release_sel(); model[7'h00] = 8'hA5;
    frame(1'b1, 7'h7F, 8'h3C, 16, -1, rx); release_sel(); model[7'h7F] = 8'h3C;
    frame(1'b1, 7'h55, 8'hFF, 16, -1, rx); release_sel(); model[7'h55] = 8'hFF;
    frame(1'b1, 7'h2A, 8'h81, 16, -1, rx); release_sel(); model[7'h2A] = 8'h81;
    sweep("R1 serial writes");

    // R2 / R3 / R4 / R5 read with nonzero data field
    frame(1'b0, 7'h2A, 8'hFF, 16, -1, rx);
    chk("R2 read 0x2A", rx, 8'h81);
    wait_clk(20);
    chk("R4 hold D0=1", miso, 1'b1);
    release_sel();
    chk("R5 idle high", miso, 1'b1);
    frame(1'b0, 7'h00, 8'h5A, 16, -1, rx);
    chk("R2 read 0x00", rx, 8'hA5);
    wait_clk(30);
    chk("R4 hold D0=1 long", miso, 1'b1);
    release_sel();
    frame(1'b0, 7'h7F, 8'hC3, 16, -1, rx);
    chk("R2 read 0x7F", rx, 8'h3C);
    wait_clk(25);
    chk("R4 hold D0=0", miso, 1'b0);
    csn = 1'b1;
    wait_clk(4);
    chk("R5 high within four clocks", miso, 1'b1);
    wait_clk(6);
    sweep("R3 read data field ignored");

    // R6 aborted write, then realigned write
    frame(1'b1, 7'h10, 8'h77, 12, -1, rx); release_sel();
    frame(1'b1, 7'h11, 8'h66, 15, -1, rx); release_sel();
    sweep("R6 short frames discarded");
    frame(1'b1, 7'h10, 8'h42, 16, -1, rx); release_sel(); model[7'h10] = 8'h42;
    sweep("R6 next frame realigned");

    // R8 local port
    @(negedge clk);
    loc_addr = 7'h20; loc_wdata = 8'h99; loc_we = 1'b1;
    @(negedge clk);
    loc_we = 1'b0; model[7'h20] = 8'h99;
    #1 chk("R8 local write/read", loc_rdata, 8'h99);
    frame(1'b0, 7'h20, 8'h00, 16, -1, rx);
    chk("R8 local write seen by serial read", rx, 8'h99);
    release_sel();

    // R7 local write during data phase
    loc_addr = 7'h20; loc_wdata = 8'h11;
    frame(1'b0, 7'h20, 8'h00, 16, 10, rx);
    chk("R7 shifted bits from snapshot", rx, 8'h99);
    release_sel(); model[7'h20] = 8'h11;
    loc_addr = 7'h20;
    #1 chk("R7 local write landed", loc_rdata, 8'h11);

    // R9 same-cycle same-address conflict
    loc_addr = 7'h30; loc_wdata = 8'h3C;
    frame(1'b1, 7'h30, 8'hC3, 16, 15, rx);
    release_sel(); model[7'h30] = 8'hC3;
    loc_addr = 7'h30;
    #1 chk("R9 serial write wins", loc_rdata, 8'hC3);
    sweep("R9 bank after conflict");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule